// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block is the burst engine inside a four-bank synchronous DRAM. When the command decoder accepts a read or write column command, it pulses `cmd_valid` with the starting column on `cmd_col` and the direction on `cmd_write`. From the next clock cycle onward, the sequencer presents one column address per beat on `beat_col` and holds `beat_valid` high for the whole burst. The number of beats comes from `mode_bl`. The order of the beats comes from `mode_interleave`: sequential wrap inside an aligned block, or XOR with the beat index.

Write bursts raise `wr_valid` together with each beat, so write data is taken with no added latency. Read bursts raise `rd_valid` once per beat, delayed so that the first strobe appears the programmed CAS latency after the command edge. The burst length and wrap order are captured when the command is accepted.

A new command accepted mid-burst cuts the running burst short and restarts the sequence from the new column. A command accepted on the last beat chains the next burst with no idle cycle. The command port has no ready signal: every pulse is accepted, and the sequencer never applies back-pressure. Every input is sampled on the rising edge of `clk`, and every output is driven from registers clocked on that edge.

Top module: `sdram_burst_seq`

## Requirements
- R1: `mode_bl` codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. `beat_valid` is high for exactly that many consecutive cycles, starting in the cycle after the edge that samples `cmd_valid`.
- R2: With `mode_interleave`=0, the column of beat i has the low log2(len) bits equal to (start + i) mod len, and all higher bits equal to those of `cmd_col`.
- R3: With `mode_interleave`=1, the column of beat i has the low log2(len) bits equal to start XOR i, and all higher bits equal to those of `cmd_col`.
- R4: For a read (`cmd_write`=0), `rd_valid` is high for len consecutive cycles. The first of these follows the command edge by 2 cycles when `mode_cl3`=0 and by 3 cycles when `mode_cl3`=1.
- R5: For a write (`cmd_write`=1), `wr_valid` is high in exactly the cycles in which `beat_valid` is high, starting the cycle after the command edge.
- R6: A read burst never raises `wr_valid`, and a write burst never raises `rd_valid`.
- R7: A command sampled on the edge that presents the last beat of a burst starts the next burst with no cycle in which `beat_valid` is low.
- R8: A command accepted mid-burst ends the running burst. The next cycle shows beat 0 of the new burst at the new column. Read strobes already in the latency pipeline still appear.
- R9: While `rst_n` is low, `beat_valid`, `wr_valid` and `rd_valid` are low. After reset is released they stay low until a command arrives.
- R10: Changes to `mode_bl` or `mode_interleave` after the command edge do not alter the length or the order of the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle column command pulse |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_col | input | COL_W | Starting column address |
| mode_bl | input | 2 | Burst length code (0:1, 1:2, 2:4, 3:8) |
| mode_interleave | input | 1 | 0 = sequential wrap, 1 = interleaved (XOR) |
| mode_cl3 | input | 1 | 0 = CAS latency 2, 1 = CAS latency 3 |
| beat_col | output | COL_W | Column address of the current beat |
| beat_valid | output | 1 | A burst beat is presented |
| wr_valid | output | 1 | Write data is taken this cycle |
| rd_valid | output | 1 | Read data is valid this cycle |

## Verification
The assertions assume that `mode_cl3` stays constant while read strobes are in flight, because the latency tap is chosen live rather than captured. They also assume that reset is not released in the middle of a check window. The assertions check column order against a model of the start column and beat index, taken at each command. The stimulus changes `mode_cl3` only while the block is idle. It alters the burst length and wrap fields mid-burst on purpose, to show that they are captured. It issues back-to-back and truncating commands only at chosen beat offsets, so that every expected strobe cycle is known in advance.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;
  // beat index width: bursts up to 8 beats
  localparam int unsigned BEAT_IDX_W = 3;

  typedef enum logic [1:0] {
    LEN_1 = 2'd0,
    LEN_2 = 2'd1,
    LEN_4 = 2'd2,
    LEN_8 = 2'd3
  } burst_len_e;

  // mask of column bits that wrap inside the burst block
  function automatic logic [BEAT_IDX_W-1:0] wrap_mask(input burst_len_e code);
    logic [BEAT_IDX_W-1:0] m;
    unique case (code)
      LEN_1:   m = 3'b000;
      LEN_2:   m = 3'b001;
      LEN_4:   m = 3'b011;
      default: m = 3'b111;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/seq_beat_counter.sv
module seq_beat_counter
  import sdram_seq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  burst_len_e            len_code,
  output logic                  active,
  output logic [BEAT_IDX_W-1:0] idx,
  output logic [BEAT_IDX_W-1:0] mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      mask   <= '0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= '0;
      mask   <= wrap_mask(len_code);
    end else if (active) begin
      if (idx == mask) begin
        active <= 1'b0;
        idx    <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/seq_col_gen.sv
module seq_col_gen
  import sdram_seq_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0]      start_col,
  input  logic [BEAT_IDX_W-1:0] idx,
  input  logic [BEAT_IDX_W-1:0] mask,
  input  logic                  interleave,
  output logic [COL_W-1:0]      col
);
  localparam int unsigned IW = BEAT_IDX_W;

  logic [IW-1:0] low_start;
  logic [IW-1:0] low_next;

  assign low_start = start_col[IW-1:0];

  always_comb begin
    if (interleave) low_next = low_start ^ idx;
    else            low_next = low_start + idx;
  end

  assign col = {start_col[COL_W-1:IW], (low_start & ~mask) | (low_next & mask)};
endmodule

// File: rtl/seq_rd_delay.sv
module seq_rd_delay #(
  parameter int unsigned MIN_CL = 2,
  parameter int unsigned MAX_CL = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic [((MAX_CL-MIN_CL+1) > 1 ? $clog2(MAX_CL-MIN_CL+1) : 1)-1:0] tap_sel,
  output logic dout
);
  // the beat register already adds one cycle, so the chain holds MAX_CL-1 stages
  localparam int unsigned NST = MAX_CL - 1;
  localparam int unsigned OFS = MIN_CL - 2;

  logic [NST-1:0] stage;

  genvar g;
  generate
    for (g = 0; g < NST; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[0] <= 1'b0;
          else        stage[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[g] <= 1'b0;
          else        stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  assign dout = stage[OFS + 32'(tap_sel)];
endmodule

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq
  import sdram_seq_pkg::*;
#(
  parameter int unsigned COL_W  = 10,
  parameter int unsigned MIN_CL = 2,
  parameter int unsigned MAX_CL = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic [COL_W-1:0] cmd_col,
  input  logic [1:0]       mode_bl,
  input  logic             mode_interleave,
  input  logic             mode_cl3,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_valid,
  output logic             wr_valid,
  output logic             rd_valid
);
  localparam int unsigned NTAP  = MAX_CL - MIN_CL + 1;
  localparam int unsigned TAP_W = (NTAP > 1) ? $clog2(NTAP) : 1;

  logic [COL_W-1:0]      start_col_q;
  logic                  ilv_q;
  logic                  is_read_q;
  logic                  active;
  logic [BEAT_IDX_W-1:0] idx;
  logic [BEAT_IDX_W-1:0] mask;

  // command capture: column, wrap order and direction are frozen per burst
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_col_q <= '0;
      ilv_q       <= 1'b0;
      is_read_q   <= 1'b0;
    end else if (cmd_valid) begin
      start_col_q <= cmd_col;
      ilv_q       <= mode_interleave;
      is_read_q   <= ~cmd_write;
    end
  end

  seq_beat_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (cmd_valid),
    .len_code (burst_len_e'(mode_bl)),
    .active   (active),
    .idx      (idx),
    .mask     (mask)
  );

  seq_col_gen #(.COL_W(COL_W)) u_col (
    .start_col  (start_col_q),
    .idx        (idx),
    .mask       (mask),
    .interleave (ilv_q),
    .col        (beat_col)
  );

  seq_rd_delay #(.MIN_CL(MIN_CL), .MAX_CL(MAX_CL)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (active & is_read_q),
    .tap_sel (TAP_W'(mode_cl3)),
    .dout    (rd_valid)
  );

  assign beat_valid = active;
  assign wr_valid   = active & ~is_read_q;
endmodule

// File: rtl/sdram_burst_seq_chk.sv
module sdram_burst_seq_chk #(
  parameter int unsigned COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_write,
  input logic [COL_W-1:0] cmd_col,
  input logic [1:0]       mode_bl,
  input logic             mode_interleave,
  input logic             mode_cl3,
  input logic [COL_W-1:0] beat_col,
  input logic             beat_valid,
  input logic             wr_valid,
  input logic             rd_valid
);
  logic [3:0]       c_len;
  logic [3:0]       c_cnt;
  logic [COL_W-1:0] c_start;
  logic             c_ilv;
  logic [2:0]       c_mask;
  logic [2:0]       c_low;
  logic [COL_W-1:0] c_seq_col;
  logic [COL_W-1:0] c_ilv_col;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_len   <= '0;
      c_cnt   <= '0;
      c_start <= '0;
      c_ilv   <= 1'b0;
    end else if (cmd_valid) begin
      c_len   <= 4'd1 << mode_bl;
      c_cnt   <= '0;
      c_start <= cmd_col;
      c_ilv   <= mode_interleave;
    end else if (beat_valid) begin
      c_cnt <= c_cnt + 4'd1;
    end
  end

  assign c_mask    = 3'(c_len - 4'd1);
  assign c_low     = c_start[2:0];
  assign c_seq_col = {c_start[COL_W-1:3], (c_low & ~c_mask) | ((c_low + c_cnt[2:0]) & c_mask)};
  assign c_ilv_col = {c_start[COL_W-1:3], c_low ^ c_cnt[2:0]};

  assert_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (c_cnt < c_len));
  assert_seq_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !c_ilv) |-> (beat_col == c_seq_col));
  assert_ilv_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && c_ilv) |-> (beat_col == c_ilv_col));
  assert_rd_cl2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_write && !mode_cl3) |-> ##2 rd_valid);
  assert_rd_cl3_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_write && mode_cl3) |-> ##3 rd_valid);
  assert_wr_now_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_write) |=> (wr_valid && beat_valid));
  assert_rd_no_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_write) |=> !wr_valid);
  assert_gapless_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> beat_valid);
  assert_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (beat_col == $past(cmd_col)));
endmodule

bind sdram_burst_seq sdram_burst_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cmd_valid       (cmd_valid),
  .cmd_write       (cmd_write),
  .cmd_col         (cmd_col),
  .mode_bl         (mode_bl),
  .mode_interleave (mode_interleave),
  .mode_cl3        (mode_cl3),
  .beat_col        (beat_col),
  .beat_valid      (beat_valid),
  .wr_valid        (wr_valid),
  .rd_valid        (rd_valid)
);

// File: tb/sdram_burst_seq_tb.sv
module sdram_burst_seq_tb;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic             cmd_write = 1'b0;
  logic [COL_W-1:0] cmd_col = '0;
  logic [1:0]       mode_bl = 2'd0;
  logic             mode_interleave = 1'b0;
  logic             mode_cl3 = 1'b0;
  logic [COL_W-1:0] beat_col;
  logic             beat_valid;
  logic             wr_valid;
  logic             rd_valid;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sdram_burst_seq #(.COL_W(COL_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_col(cmd_col), .mode_bl(mode_bl), .mode_interleave(mode_interleave),
    .mode_cl3(mode_cl3), .beat_col(beat_col), .beat_valid(beat_valid),
    .wr_valid(wr_valid), .rd_valid(rd_valid)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_col(input int col, input int blc, input bit ilv, input int i);
    int len, m, lo;
    len = 1 << blc;
    m   = len - 1;
    lo  = ilv ? ((col & m) ^ i) : (((col & m) + i) % len);
    return (col & ~m & ((1 << COL_W) - 1)) | lo;
  endfunction

  // issue one burst and check every strobe and column until it drains
  task automatic run_burst(input int col, input int blc, input bit ilv, input bit wr,
                           input bit cl3, input bit scramble, input string tag);
    int len, cl;
    len = 1 << blc;
    cl  = cl3 ? 3 : 2;
    @(negedge clk);
    mode_bl = 2'(blc); mode_interleave = ilv; mode_cl3 = cl3;
    cmd_valid = 1'b1; cmd_write = wr; cmd_col = COL_W'(col);
    for (int j = 1; j <= len + cl + 1; j++) begin
      @(negedge clk);
      if (j == 1) begin
        cmd_valid = 1'b0;
        if (scramble) begin mode_bl = 2'(~blc); mode_interleave = ~ilv; end
      end
      chk({tag, " R1 beat_valid"}, int'(beat_valid), int'(j <= len));
      if (j <= len) chk({tag, (ilv ? " R3" : " R2"), " beat_col"}, int'(beat_col), exp_col(col, blc, ilv, j - 1));
      chk({tag, " R5 R6 wr_valid"}, int'(wr_valid), int'(wr && j <= len));
      chk({tag, " R4 R6 rd_valid"}, int'(rd_valid), int'(!wr && j >= cl && j < cl + len));
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 reset beat_valid", int'(beat_valid), 0);
    chk("R9 reset wr_valid", int'(wr_valid), 0);
    chk("R9 reset rd_valid", int'(rd_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 idle beat_valid", int'(beat_valid), 0);
    chk("R9 idle rd_valid", int'(rd_valid), 0);
  endtask

  task automatic test_back_to_back();
    @(negedge clk);
    mode_bl = 2'd2; mode_interleave = 1'b0; mode_cl3 = 1'b0;
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_col = 10'h012;
    for (int j = 1; j <= 9; j++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R7 gapless beat_valid", int'(beat_valid), int'(j <= 8));
      if (j <= 4) chk("R7 first beat_col", int'(beat_col), exp_col('h012, 2, 0, j - 1));
      else if (j <= 8) chk("R7 second beat_col", int'(beat_col), exp_col('h127, 2, 0, j - 5));
      if (j == 4) begin cmd_valid = 1'b1; cmd_col = 10'h127; end
    end
  endtask

  task automatic test_truncate();
    @(negedge clk);
    mode_bl = 2'd3; mode_interleave = 1'b0; mode_cl3 = 1'b0;
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_col = 10'h010;
    for (int j = 1; j <= 8; j++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      if (j <= 2) begin
        chk("R8 first wr_valid", int'(wr_valid), 1);
        chk("R8 first beat_col", int'(beat_col), exp_col('h010, 3, 0, j - 1));
      end else if (j <= 6) begin
        chk("R8 new beat_col", int'(beat_col), exp_col('h02c, 2, 1, j - 3));
        chk("R8 new wr_valid", int'(wr_valid), 0);
      end else begin
        chk("R8 ended beat_valid", int'(beat_valid), 0);
      end
      chk("R8 rd_valid", int'(rd_valid), int'(j >= 4 && j <= 7));
      if (j == 2) begin
        cmd_valid = 1'b1; cmd_write = 1'b0; cmd_col = 10'h02c;
        mode_bl = 2'd2; mode_interleave = 1'b1;
      end
    end
  endtask

  task automatic test_reset_mid_burst();
    @(negedge clk);
    mode_bl = 2'd3; cmd_valid = 1'b1; cmd_write = 1'b1; cmd_col = 10'h0;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 mid-burst reset beat_valid", int'(beat_valid), 0);
    chk("R9 mid-burst reset wr_valid", int'(wr_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 after reset beat_valid", int'(beat_valid), 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    test_reset();
    run_burst('h105, 3, 0, 0, 0, 0, "seq8 rd cl2");
    run_burst('h105, 3, 1, 0, 0, 0, "ilv8 rd cl2");
    run_burst('h23e, 2, 0, 1, 0, 0, "seq4 wr");
    run_burst('h23e, 2, 1, 0, 1, 0, "ilv4 rd cl3");
    run_burst('h3ff, 0, 0, 0, 1, 0, "len1 rd cl3");
    run_burst('h0c3, 1, 1, 1, 0, 0, "ilv2 wr");
    run_burst('h0c3, 1, 0, 0, 0, 0, "seq2 rd");
    run_burst('h2b6, 3, 0, 1, 0, 1, "R10 mode change wr");
    run_burst('h2b6, 2, 1, 0, 1, 1, "R10 mode change rd");
    test_back_to_back();
    test_truncate();
    test_reset_mid_burst();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule